// File: doc/BRIEF.md
# Synchronized Quad DAC Update Controller

This block keeps four 12-bit output values for an external four-channel serial DAC and sends them only when software asks. Each channel has a 16-bit register. Software can write new values into the registers without touching the analog outputs. The top bit of every register is one shared flag. Writing it as 1 in any of the four registers pushes all four staged values to the converter in one burst. While that burst is in flight, the same bit reads back as 1.

Each channel goes out as its own 16-bit serial frame, framed by an active-low select. After the fourth frame, an active-low load pulse makes every converter output move at the same moment. The serial clock comes from the system clock through a half-period divider. With the default divider of 2 and a 100 MHz clock, a whole burst takes 274 cycles, which is 2.74 µs. Any write that arrives during a burst is dropped, and a sticky error flag reports it.

Top module: `quad_dac_sync`

## Requirements
- R1: After reset, all four staged values read 0. The busy bit reads 0, `busy_wr_err` is 0, and the serial lines are idle: `dac_csn`=1, `dac_ldn`=1, `dac_sclk`=0.
- R2: An accepted write with bit 15 = 0 stores `wr_data[11:0]` into the channel selected by `wr_addr` (0..3). That value reads back on `rd_data[11:0]` from the next cycle. Bits 14:12 always read 0. No serial activity follows.
- R3: An accepted write with bit 15 = 1 stores its value and starts a burst. `rd_data[15]` reads 1 from the cycle after the write for exactly HALF_DIV*(4*34+1) cycles, which is 274 with the defaults.
- R4: A burst sends four frames in channel order 0,1,2,3. Each frame is 16 bits, MSB first: bits 15:14 hold the channel number, bits 13:12 hold the control code 2'b01, and bits 11:0 hold the staged value. Data is stable at every rising `dac_sclk`, and `dac_csn` rises between frames.
- R5: After the fourth frame, `dac_ldn` goes low exactly once per burst, for HALF_DIV cycles, while `dac_csn` is high.
- R6: A commit whose values are all unchanged still sends the complete burst with the same frames.
- R7: A write made while busy is ignored. It changes no staged value and does not restart the burst. `busy_wr_err` becomes 1 in the cycle after the rejected write and stays 1 until the next accepted write clears it.
- R8: The commit bit works the same way in any of the four channel registers.
- R9: `dac_sclk` is high only while `dac_csn` is low. `dac_csn` and `dac_ldn` are never low together. The lines are idle whenever no burst is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 2 | Channel register selected for the write |
| wr_data | input | 16 | Write data: bit 15 is commit, bits 11:0 are the value |
| rd_addr | input | 2 | Channel register selected for reading |
| rd_data | output | 16 | Bit 15 is busy, bits 14:12 are zero, bits 11:0 are the staged value |
| busy_wr_err | output | 1 | Sticky flag set when a write is rejected during a burst |
| dac_csn | output | 1 | Active-low frame select to the converter |
| dac_sclk | output | 1 | Serial clock to the converter |
| dac_mosi | output | 1 | Serial data to the converter |
| dac_ldn | output | 1 | Active-low simultaneous-load strobe |

## Verification
The assertions assume that `wr_en` is a clean single-cycle strobe with settled address and data, and that reset is held for at least one clock edge. They also assume that software never relies on a write made while busy, because the block rejects such writes. The stimulus drives every input on the falling edge, so each write is seen by exactly one rising edge. Writes during a burst are placed on purpose, including one on the very edge where busy drops, so that the rejection path is covered without breaking those assumptions.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
   typedef struct packed {
      logic csn;
      logic sclk;
      logic mosi;
      logic ldn;
   } dac_line_t;

   localparam dac_line_t LINE_IDLE = '{csn: 1'b1, sclk: 1'b0, mosi: 1'b0, ldn: 1'b1};
endpackage

// File: rtl/qdac_stage.sv
module qdac_stage #(
   parameter int NUM_CH = 4,
   parameter int VAL_W  = 12,
   parameter int WORD_W = 16,
   localparam int ADDR_W = $clog2(NUM_CH)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  logic [WORD_W-1:0]       wr_data,
   input  logic                    busy,
   output logic [NUM_CH*VAL_W-1:0] vals,
   output logic                    start,
   output logic                    err
);
   logic accept;
   assign accept = wr_en && !busy;
   assign start  = accept && wr_data[WORD_W-1];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      logic [VAL_W-1:0] val_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            val_q <= '0;
         else if (accept && wr_addr == ADDR_W'(c))
            val_q <= wr_data[VAL_W-1:0];
      end
      assign vals[c*VAL_W +: VAL_W] = val_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         err <= 1'b0;
      else if (wr_en)
         err <= busy;
   end

   // R7: a write during a burst leaves every staged value untouched
   assert_busy_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && busy) |=> $stable(vals));
endmodule

// File: rtl/qdac_seq.sv
module qdac_seq #(
   parameter int NUM_CH   = 4,
   parameter int WORD_W   = 16,
   parameter int HALF_DIV = 2,
   localparam int HPW   = 2*WORD_W + 2,
   localparam int SUB_W = $clog2(HPW),
   localparam int IDX_W = $clog2(NUM_CH + 1),
   localparam int DIV_W = $clog2(HALF_DIV + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic             busy,
   output logic [IDX_W-1:0] word_idx,
   output logic [SUB_W-1:0] sub_idx
);
   logic [DIV_W-1:0] div_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         div_q    <= '0;
         sub_idx  <= '0;
         word_idx <= '0;
      end else if (!busy) begin
         if (start) begin
            busy     <= 1'b1;
            div_q    <= '0;
            sub_idx  <= '0;
            word_idx <= '0;
         end
      end else if (div_q == DIV_W'(HALF_DIV - 1)) begin
         div_q <= '0;
         if (word_idx == IDX_W'(NUM_CH)) begin
            busy <= 1'b0;
         end else if (sub_idx == SUB_W'(HPW - 1)) begin
            sub_idx  <= '0;
            word_idx <= word_idx + 1'b1;
         end else begin
            sub_idx <= sub_idx + 1'b1;
         end
      end else begin
         div_q <= div_q + 1'b1;
      end
   end

   // R3: a commit accepted while idle raises busy on the next edge
   assert_commit_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);
   // R7: busy never rises without an accepted commit
   assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));
   // R5: a burst ends only after the load phase
   assert_end_after_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(word_idx) == IDX_W'(NUM_CH));
endmodule

// File: rtl/qdac_serial.sv
module qdac_serial
   import qdac_pkg::*;
#(
   parameter int NUM_CH    = 4,
   parameter int VAL_W     = 12,
   parameter int WORD_W    = 16,
   parameter int CTRL_CODE = 1,
   parameter bit REG_LINES = 1'b1,
   localparam int HPW   = 2*WORD_W + 2,
   localparam int SUB_W = $clog2(HPW),
   localparam int IDX_W = $clog2(NUM_CH + 1),
   localparam int CH_W  = $clog2(NUM_CH),
   localparam int CTL_W = WORD_W - VAL_W - CH_W,
   localparam int BIT_W = $clog2(WORD_W)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    busy,
   input  logic [IDX_W-1:0]        word_idx,
   input  logic [SUB_W-1:0]        sub_idx,
   input  logic [NUM_CH*VAL_W-1:0] vals,
   output dac_line_t               line
);
   logic [WORD_W-1:0] frame [NUM_CH];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_frame
      assign frame[c] = {CH_W'(c), CTL_W'(CTRL_CODE), vals[c*VAL_W +: VAL_W]};
   end

   dac_line_t         nxt;
   logic [WORD_W-1:0] cur;
   logic [BIT_W-1:0]  bit_pos;

   always_comb begin
      nxt     = LINE_IDLE;
      cur     = frame[word_idx[CH_W-1:0]];
      bit_pos = BIT_W'(WORD_W - 1) - BIT_W'(sub_idx >> 1);
      if (busy) begin
         if (word_idx == IDX_W'(NUM_CH)) begin
            nxt.ldn = 1'b0;
         end else if (sub_idx < SUB_W'(2*WORD_W)) begin
            nxt.csn  = 1'b0;
            nxt.sclk = sub_idx[0];
            nxt.mosi = cur[bit_pos];
         end else if (sub_idx == SUB_W'(2*WORD_W)) begin
            nxt.csn = 1'b0;
         end
      end
   end

   if (REG_LINES) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) line <= LINE_IDLE;
         else        line <= nxt;
      end
      // R9: lines are idle one edge after an idle cycle
      assert_idle_lines_R9: assert property (@(posedge clk) disable iff (!rst_n)
         !$past(busy) |-> (line == LINE_IDLE));
   end else begin : g_comb
      assign line = nxt;
      // R9: lines are idle whenever no burst is running
      assert_idle_lines_R9: assert property (@(posedge clk) disable iff (!rst_n)
         !busy |-> (line == LINE_IDLE));
   end
endmodule

// File: rtl/quad_dac_sync.sv
module quad_dac_sync
   import qdac_pkg::*;
#(
   parameter int NUM_CH    = 4,
   parameter int VAL_W     = 12,
   parameter int WORD_W    = 16,
   parameter int HALF_DIV  = 2,
   parameter int CTRL_CODE = 1,
   parameter bit REG_LINES = 1'b1,
   localparam int ADDR_W = $clog2(NUM_CH),
   localparam int HPW    = 2*WORD_W + 2,
   localparam int SUB_W  = $clog2(HPW),
   localparam int IDX_W  = $clog2(NUM_CH + 1),
   localparam int PAD_W  = WORD_W - 1 - VAL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [WORD_W-1:0] rd_data,
   output logic              busy_wr_err,
   output logic              dac_csn,
   output logic              dac_sclk,
   output logic              dac_mosi,
   output logic              dac_ldn
);
   if (NUM_CH < 2)                          begin : g_bad_ch   $error("NUM_CH must be at least 2"); end
   if (HALF_DIV < 1)                        begin : g_bad_div  $error("HALF_DIV must be at least 1"); end
   if (WORD_W - VAL_W - ADDR_W < 1)         begin : g_bad_word $error("frame too narrow for control code"); end
   if (PAD_W < 1)                           begin : g_bad_pad  $error("register needs a pad bit"); end

   logic                    busy, start;
   logic [NUM_CH*VAL_W-1:0] vals;
   logic [IDX_W-1:0]        word_idx;
   logic [SUB_W-1:0]        sub_idx;
   dac_line_t               line;

   qdac_stage #(.NUM_CH(NUM_CH), .VAL_W(VAL_W), .WORD_W(WORD_W)) u_stage (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .busy(busy), .vals(vals), .start(start), .err(busy_wr_err));

   qdac_seq #(.NUM_CH(NUM_CH), .WORD_W(WORD_W), .HALF_DIV(HALF_DIV)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
      .word_idx(word_idx), .sub_idx(sub_idx));

   qdac_serial #(.NUM_CH(NUM_CH), .VAL_W(VAL_W), .WORD_W(WORD_W),
                 .CTRL_CODE(CTRL_CODE), .REG_LINES(REG_LINES)) u_serial (
      .clk(clk), .rst_n(rst_n), .busy(busy), .word_idx(word_idx),
      .sub_idx(sub_idx), .vals(vals), .line(line));

   assign dac_csn  = line.csn;
   assign dac_sclk = line.sclk;
   assign dac_mosi = line.mosi;
   assign dac_ldn  = line.ldn;
   assign rd_data  = {busy, {PAD_W{1'b0}}, vals[int'(rd_addr)*VAL_W +: VAL_W]};

   // R9: select and load are never low together
   assert_csn_ldn_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(!dac_csn && !dac_ldn));
   // R9: the serial clock pulses only inside a frame
   assert_sclk_in_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
      dac_sclk |-> !dac_csn);
   // R4: data does not move while the serial clock is high
   assert_mosi_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (dac_sclk && $past(dac_sclk)) |-> $stable(dac_mosi));
endmodule

// File: tb/quad_dac_sync_bench.sv
module quad_dac_sync_bench;
   localparam int CLK_P = 10;
   localparam int HALF  = 2;
   localparam int TOT   = HALF * (4*34 + 1);

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [1:0]  rd_addr = '0;
   logic [15:0] rd_data;
   logic        busy_wr_err, dac_csn, dac_sclk, dac_mosi, dac_ldn;

   quad_dac_sync #(.HALF_DIV(HALF)) u_quad_dac_sync (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .busy_wr_err(busy_wr_err),
      .dac_csn(dac_csn), .dac_sclk(dac_sclk), .dac_mosi(dac_mosi), .dac_ldn(dac_ldn));

   always #(CLK_P/2) clk = ~clk;

   int vectors = 0;
   int miscompares = 0;
   bit finished = 0;
   bit rd_auto = 1;

   task automatic fail(string req, string what, int act, int exp);
      miscompares++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
   endtask

   task automatic check(string req, string what, int act, int exp);
      vectors++;
      if (act != exp) fail(req, what, act, exp);
   endtask

   // behavioural reference model
   logic [11:0] m_val [4];
   int          m_cnt = 0;
   bit          m_err = 0;
   logic [15:0] exp_q [$];
   int          old_cnt;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < 4; c++) m_val[c] = '0;
         m_cnt = 0;
         m_err = 0;
      end else begin
         old_cnt = m_cnt;
         if (m_cnt > 0) m_cnt--;
         if (wr_en) begin
            if (old_cnt > 0) m_err = 1;
            else begin
               m_val[wr_addr] = wr_data[11:0];
               m_err = 0;
               if (wr_data[15]) begin
                  m_cnt = TOT;
                  for (int c = 0; c < 4; c++) exp_q.push_back({2'(c), 2'b01, m_val[c]});
               end
            end
         end
      end
   end

   // per-clock comparison
   always @(negedge clk) begin
      if (rst_n) begin
         vectors++;
         if (rd_data[11:0] !== m_val[rd_addr]) fail("R2", "staged value", rd_data[11:0], m_val[rd_addr]);
         if (rd_data[14:12] !== 3'b000) fail("R2", "pad bits", rd_data[14:12], 0);
         if (rd_data[15] !== (m_cnt > 0)) fail("R3", "busy bit", rd_data[15], m_cnt > 0);
         if (busy_wr_err !== m_err) fail("R7", "busy write flag", busy_wr_err, m_err);
         if (!dac_csn && !dac_ldn) fail("R9", "csn and ldn both low", 0, 1);
         if (dac_sclk && dac_csn) fail("R9", "sclk outside frame", 1, 0);
         if (rd_auto) rd_addr = rd_addr + 1'b1;
      end
   end

   // serial receiver
   int          rx_bits = 0;
   int          rx_words = 0;
   int          csn_falls = 0;
   int          ld_count = 0;
   logic [15:0] rx_sh = '0;
   logic [15:0] e_word;
   time         t_ld;
   bit          ld_armed = 0;

   always @(posedge dac_sclk) if (dac_csn === 1'b0) begin
      rx_sh = {rx_sh[14:0], dac_mosi};
      rx_bits++;
   end
   always @(negedge dac_csn) csn_falls++;
   always @(posedge dac_csn) if (rx_bits > 0) begin
      vectors++;
      if (rx_bits != 16) fail("R4", "frame length", rx_bits, 16);
      if (exp_q.size() == 0) fail("R4", "unexpected frame", rx_sh, 0);
      else begin
         e_word = exp_q.pop_front();
         if (rx_sh !== e_word) fail("R4", "frame content", rx_sh, e_word);
      end
      rx_bits = 0;
      rx_words++;
   end
   always @(negedge dac_ldn) if (rst_n) begin
      vectors++;
      ld_count++;
      t_ld = $time;
      ld_armed = 1;
      if (exp_q.size() != 0) fail("R5", "load before all frames", exp_q.size(), 0);
      if (rx_words % 4 != 0) fail("R5", "frames before load", rx_words, 4);
   end
   always @(posedge dac_ldn) if (ld_armed) begin
      ld_armed = 0;
      check("R5", "load pulse width", int'(($time - t_ld) / CLK_P), HALF);
   end

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_idle();
      while (m_cnt > 0) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   task automatic rd_chk(string req, input logic [1:0] a, int exp);
      rd_auto = 0;
      rd_addr = a;
      #1;
      check(req, "read back", rd_data[11:0], exp);
      @(negedge clk);
      rd_auto = 1;
   endtask

   int ld0, w0, n_busy;

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", "csn idle", dac_csn, 1);
      check("R1", "ldn idle", dac_ldn, 1);
      check("R1", "sclk idle", dac_sclk, 0);
      check("R1", "err clear", busy_wr_err, 0);
      check("R1", "read zero", rd_data, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2: staging without commit
      wr(0, 16'h7ABC); wr(1, 16'h0123); wr(2, 16'h0FFF); wr(3, 16'h0000);
      repeat (40) @(negedge clk);
      check("R2", "no frames", csn_falls, 0);
      check("R2", "no load", ld_count, 0);
      rd_chk("R2", 0, 12'hABC);

      // R3 R4 R5 R8: commit through channel 2
      ld0 = ld_count; w0 = rx_words;
      wr(2, 16'h8555);
      n_busy = 0;
      while (rd_data[15]) begin n_busy++; @(negedge clk); end
      check("R3", "busy length", n_busy, TOT);
      repeat (4) @(negedge clk);
      check("R5", "one load", ld_count, ld0 + 1);
      check("R4", "four frames", rx_words, w0 + 4);
      check("R8", "commit via ch2", exp_q.size(), 0);

      // R7: write while busy is dropped
      ld0 = ld_count;
      wr(1, 16'h8001);
      repeat (50) @(negedge clk);
      wr(3, 16'h8777);
      check("R7", "err raised", busy_wr_err, 1);
      wait_idle();
      check("R7", "no restart", ld_count, ld0 + 1);
      check("R7", "err sticky", busy_wr_err, 1);
      rd_chk("R7", 3, 0);

      // R6: unchanged commit via ch3, also clears error
      w0 = rx_words;
      wr(3, 16'h8000);
      check("R7", "err cleared", busy_wr_err, 0);
      wait_idle();
      check("R6", "repeat burst", rx_words, w0 + 4);

      // R7 boundary: write on the edge where busy drops
      wr(0, 16'h8FFF);
      while (m_cnt != 1) @(negedge clk);
      wr_en = 1'b1; wr_addr = 2'd1; wr_data = 16'h0AAA;
      @(negedge clk);
      wr_en = 1'b0;
      check("R7", "last busy edge rejects", busy_wr_err, 1);
      rd_chk("R7", 1, 12'h001);
      wr(1, 16'h0AAA);
      rd_chk("R2", 1, 12'hAAA);
      rd_chk("R8", 0, 12'hFFF);
      wait_idle();

      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         fail("R3", "watchdog expired", 1, 0);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule